// File: doc/BRIEF.md
# Dual-Channel Programmable Divided Clock Generator

This block produces two independent divided output levels from a single system clock domain. Each channel counts tick pulses from one of two reference clock-enable inputs. The channel's output goes high for the part of each divided period that lies past a programmable compare point. Software programs a channel through one 32-bit control word. That word holds, for each channel, an enable, a source select, a 4-bit divide value and a 4-bit compare value.

Each channel owns one 16-bit lane of the control word, and writes carry a per-lane select. Reprogramming one channel therefore never disturbs the other. A channel keeps a shadow copy of its divide and compare values and loads that copy only at the end of a period, so a change made while the channel is running cannot cut a period short. The whole control word can be read back at any time.

Top module: `dclkgen_top`

## Requirements
- R1: After reset the control word reads 0x00000000, both outputs are low and both channels are disabled.
- R2: Channel n uses lane bits [16n+15:16n]. Within a lane, bit 0 is the enable, bit 1 is the source select, bits 7:4 are the divide value and bits 11:8 are the compare value. All other bits ignore writes and read back as zero, so writing all ones reads back 0x0FF30FF3.
- R3: An enabled channel counts its selected ticks from phase 0 up to its active divide value and then wraps to phase 0, so one period lasts (divide + 1) ticks.
- R4: While a channel's enable bit is 0, its output is low and its phase is held at 0. After it is enabled, counting starts at phase 0 using the divide and compare values written with the enable.
- R5: With an active divide value above 0, the output is low while the phase is less than or equal to the active compare value and high otherwise. A compare value of divide or more keeps the output low. The compare value ((divide + 2) / 2) - 1 gives (divide + 1) / 2 high ticks per period.
- R6: With an active divide value of 0, an enabled channel's output follows the selected tick input in the same cycle.
- R7: Source select 0 counts ref_tick_a and source select 1 counts ref_tick_b. Pulses on the unselected input have no effect on the channel.
- R8: A divide or compare value written while the channel is enabled takes effect only at the next wrap. Until then the current period runs with the old values.
- R9: A write updates only the lanes whose wr_sel bit is 1. Other lanes keep their value, and a write with wr_sel = 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_sel | input | 2 | Per-lane write select; bit n enables lane n |
| wr_data | input | 32 | Write data for the control word |
| rd_data | output | 32 | Current control word, undefined bits zero |
| ref_tick_a | input | 1 | First reference clock-enable pulse |
| ref_tick_b | input | 1 | Second reference clock-enable pulse |
| clk_out | output | 2 | Divided output level, bit n for channel n |

## Verification
The output is a pure function of the phase counter and the active shadow values. A counter that skips, wraps at the wrong value or fails to hold while disabled therefore shows up as a wrong level on clk_out within one period, that is, at most sixteen selected ticks. A shadow value that loads at the wrong time shifts the high/low boundary in the very period that follows the write. A lane decode error shows up on rd_data in the cycle right after the write. The sweep runs both channels at once, each with its own divide, compare and source, under pseudo-random tick patterns, and compares every output level on every cycle against an arithmetic phase model.

// File: rtl/dclkgen_pkg.sv
package dclkgen_pkg;

  localparam int NUM_CH  = 2;
  localparam int LANE_W  = 16;
  localparam int REG_W   = NUM_CH * LANE_W;
  localparam int CNT_W   = 4;
  localparam int BIT_ON  = 0;
  localparam int BIT_SRC = 1;
  localparam int DIV_LSB = 4;
  localparam int CMP_LSB = 8;

  typedef struct packed {
    logic [CNT_W-1:0] cmp;
    logic [CNT_W-1:0] div;
    logic             src;
    logic             on;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);

  function automatic chan_cfg_t unpack_lane(input logic [LANE_W-1:0] lane);
    chan_cfg_t c;
    c.on  = lane[BIT_ON];
    c.src = lane[BIT_SRC];
    c.div = lane[DIV_LSB +: CNT_W];
    c.cmp = lane[CMP_LSB +: CNT_W];
    return c;
  endfunction

  function automatic logic [LANE_W-1:0] pack_lane(input chan_cfg_t c);
    logic [LANE_W-1:0] lane;
    lane = '0;
    lane[BIT_ON]              = c.on;
    lane[BIT_SRC]             = c.src;
    lane[DIV_LSB +: CNT_W]    = c.div;
    lane[CMP_LSB +: CNT_W]    = c.cmp;
    return lane;
  endfunction

  // End of a divided period: the phase has reached the active divide value.
  function automatic logic period_end(input logic [CNT_W-1:0] phase,
                                      input logic [CNT_W-1:0] div);
    return phase >= div;
  endfunction

  // Output level for a phase inside a period of length div+1 (div > 0).
  function automatic logic phase_level(input logic [CNT_W-1:0] phase,
                                       input logic [CNT_W-1:0] cmp);
    return phase > cmp;
  endfunction

endpackage

// File: rtl/dclkgen_regs.sv
module dclkgen_regs
  import dclkgen_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [NUM_CH-1:0]          wr_sel,
  input  logic [REG_W-1:0]           wr_data,
  output chan_cfg_t [NUM_CH-1:0]     cfg_q,
  output chan_cfg_t [NUM_CH-1:0]     cfg_nxt,
  output logic [REG_W-1:0]           rd_data
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    chan_cfg_t lane_q;
    chan_cfg_t lane_d;
    logic      lane_hit;

    assign lane_hit = wr_en && wr_sel[g];
    assign lane_d   = lane_hit ? unpack_lane(wr_data[g*LANE_W +: LANE_W]) : lane_q;

    always_ff @(posedge clk) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign cfg_q[g]                      = lane_q;
    assign cfg_nxt[g]                    = lane_d;
    assign rd_data[g*LANE_W +: LANE_W]   = pack_lane(lane_q);
  end

endmodule

// File: rtl/dclkgen_chan.sv
module dclkgen_chan
  import dclkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  chan_cfg_t        cfg_q,
  input  chan_cfg_t        cfg_nxt,
  input  logic             tick_a,
  input  logic             tick_b,
  output logic             level,
  output logic [CNT_W-1:0] phase_o,
  output logic [CNT_W-1:0] div_act_o,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic             step_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] div_act_q;
  logic [CNT_W-1:0] cmp_act_q;
  logic             tick_sel;
  logic             step;
  logic             wrap;

  assign tick_sel = cfg_q.src ? tick_b : tick_a;
  assign step     = cfg_q.on & tick_sel;
  assign wrap     = step & period_end(phase_q, div_act_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= '0;
      div_act_q <= '0;
      cmp_act_q <= '0;
    end else if (!cfg_q.on) begin
      phase_q   <= '0;
      div_act_q <= cfg_nxt.div;
      cmp_act_q <= cfg_nxt.cmp;
    end else if (wrap) begin
      phase_q   <= '0;
      div_act_q <= cfg_q.div;
      cmp_act_q <= cfg_q.cmp;
    end else if (step) begin
      phase_q   <= phase_q + 1'b1;
    end
  end

  always_comb begin
    if (!cfg_q.on)            level = 1'b0;
    else if (div_act_q == '0) level = step;
    else                      level = phase_level(phase_q, cmp_act_q);
  end

  assign phase_o   = phase_q;
  assign div_act_o = div_act_q;
  assign cmp_act_o = cmp_act_q;
  assign step_o    = step;
  assign wrap_o    = wrap;

endmodule

// File: rtl/dclkgen_top.sv
module dclkgen_top
  import dclkgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              ref_tick_a,
  input  logic              ref_tick_b,
  output logic [NUM_CH-1:0] clk_out
);

  chan_cfg_t [NUM_CH-1:0]            cfg_q;
  chan_cfg_t [NUM_CH-1:0]            cfg_nxt;
  logic [NUM_CH-1:0][CNT_W-1:0]      phase_w;
  logic [NUM_CH-1:0][CNT_W-1:0]      div_act_w;
  logic [NUM_CH-1:0][CNT_W-1:0]      cmp_act_w;
  logic [NUM_CH-1:0]                 step_w;
  logic [NUM_CH-1:0]                 wrap_w;

  dclkgen_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cfg_q   (cfg_q),
    .cfg_nxt (cfg_nxt),
    .rd_data (rd_data)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic             lvl;
    logic [CNT_W-1:0] ph;
    logic [CNT_W-1:0] dv;
    logic [CNT_W-1:0] cm;
    logic             st;
    logic             wp;

    dclkgen_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_q     (cfg_q[g]),
      .cfg_nxt   (cfg_nxt[g]),
      .tick_a    (ref_tick_a),
      .tick_b    (ref_tick_b),
      .level     (lvl),
      .phase_o   (ph),
      .div_act_o (dv),
      .cmp_act_o (cm),
      .step_o    (st),
      .wrap_o    (wp)
    );

    assign clk_out[g]   = lvl;
    assign phase_w[g]   = ph;
    assign div_act_w[g] = dv;
    assign cmp_act_w[g] = cm;
    assign step_w[g]    = st;
    assign wrap_w[g]    = wp;
  end

endmodule

// File: rtl/dclkgen_sva.sv
module dclkgen_sva
  import dclkgen_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [NUM_CH-1:0]           wr_sel,
  input logic [REG_W-1:0]            rd_data,
  input logic [NUM_CH-1:0]           clk_out,
  input logic [NUM_CH-1:0][CNT_W-1:0] phase_w,
  input logic [NUM_CH-1:0][CNT_W-1:0] div_act_w,
  input logic [NUM_CH-1:0][CNT_W-1:0] cmp_act_w,
  input logic [NUM_CH-1:0]           step_w,
  input logic [NUM_CH-1:0]           wrap_w
);

  localparam logic [LANE_W-1:0] LANE_MASK = pack_lane(chan_cfg_t'({CFG_W{1'b1}}));
  localparam logic [REG_W-1:0]  REG_MASK  = {NUM_CH{LANE_MASK}};

  p_undef_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~REG_MASK) == '0);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      phase_w[g] <= div_act_w[g]);

    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_w[g] |=> phase_w[g] == '0);

    p_step_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_w[g] && !wrap_w[g]) |=> phase_w[g] == $past(phase_w[g]) + 1'b1);

    p_off_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[g*LANE_W + BIT_ON] |-> !clk_out[g]);

    p_off_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[g*LANE_W + BIT_ON] |=> phase_w[g] == '0);

    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[g*LANE_W + BIT_ON] && !wrap_w[g])
        |=> ($stable(div_act_w[g]) && $stable(cmp_act_w[g])));

    p_lane_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel[g]) |=> $stable(rd_data[g*LANE_W +: LANE_W]));
  end

endmodule

bind dclkgen_top dclkgen_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .rd_data   (rd_data),
  .clk_out   (clk_out),
  .phase_w   (phase_w),
  .div_act_w (div_act_w),
  .cmp_act_w (cmp_act_w),
  .step_w    (step_w),
  .wrap_w    (wrap_w)
);

// File: tb/dclkgen_top_test.sv
`timescale 1ns/1ps
module dclkgen_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'b00;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ref_tick_a = 1'b0;
  logic        ref_tick_b = 1'b0;
  logic [1:0]  clk_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dclkgen_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_data(rd_data),
    .ref_tick_a(ref_tick_a), .ref_tick_b(ref_tick_b), .clk_out(clk_out)
  );

  // Arithmetic model of the requirements
  logic [31:0] reg_m = '0;
  int ph [2];
  int dact [2];
  int cact [2];
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] masked(input logic [31:0] d);
    return d & 32'h0FF3_0FF3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      reg_m = '0;
      for (int c = 0; c < 2; c++) begin ph[c] = 0; dact[c] = 0; cact[c] = 0; end
    end else begin
      logic [31:0] nreg;
      nreg = reg_m;
      for (int c = 0; c < 2; c++)
        if (wr_en && wr_sel[c]) nreg[16*c +: 16] = masked(wr_data)[16*c +: 16];
      for (int c = 0; c < 2; c++) begin
        logic tk;
        tk = reg_m[16*c+1] ? ref_tick_b : ref_tick_a;
        if (!reg_m[16*c]) begin
          ph[c] = 0;
          dact[c] = int'(nreg[16*c+4 +: 4]);
          cact[c] = int'(nreg[16*c+8 +: 4]);
        end else if (tk) begin
          if (ph[c] >= dact[c]) begin
            ph[c] = 0;
            dact[c] = int'(reg_m[16*c+4 +: 4]);
            cact[c] = int'(reg_m[16*c+8 +: 4]);
          end else ph[c] = ph[c] + 1;
        end
      end
      reg_m = nreg;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string tag);
    for (int c = 0; c < 2; c++) begin
      logic tk, e;
      tk = reg_m[16*c+1] ? ref_tick_b : ref_tick_a;
      if (!reg_m[16*c]) e = 1'b0;
      else if (dact[c] == 0) e = tk;
      else e = (ph[c] > cact[c]);
      check($sformatf("%s ch%0d", tag, c), {31'd0, clk_out[c]}, {31'd0, e});
    end
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    ref_tick_a = 1'b0; ref_tick_b = 1'b0;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_sel = 2'b00;
  endtask

  task automatic run_rand(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_tick_a = lfsr[0] | lfsr[3];
      ref_tick_b = lfsr[5] & lfsr[9];
      #1;
      check_outs(tag);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
  endtask

  task automatic run_fixed(input int n, input logic ta, input logic tb, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_tick_a = ta; ref_tick_b = tb;
      #1;
      check_outs(tag);
    end
  endtask

  function automatic logic [15:0] lane(input int en, input int src, input int d, input int c);
    logic [15:0] l;
    l = '0;
    l[0] = en[0]; l[1] = src[0]; l[7:4] = d[3:0]; l[11:8] = c[3:0];
    return l;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ref_tick_a = 1'b1; ref_tick_b = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 reset rd_data", rd_data, 32'h0);
    check("R1 reset clk_out", {30'd0, clk_out}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 after reset rd_data", rd_data, 32'h0);
    check("R1 after reset clk_out", {30'd0, clk_out}, 32'h0);

    // R2 readback and undefined bits
    do_write(2'b11, 32'hFFFF_FFFF);
    check("R2 all ones readback", rd_data, 32'h0FF3_0FF3);
    do_write(2'b11, 32'h0);
    check("R2 clear readback", rd_data, 32'h0);

    // R9 lane isolation
    do_write(2'b11, 32'h0C51_0000);
    check("R9 lane1 load", rd_data, 32'h0C51_0000);
    do_write(2'b01, 32'hFFFF_0A63);
    check("R9 lane0 only", rd_data, 32'h0C51_0A63);
    do_write(2'b10, 32'h0000_FFFF);
    check("R9 lane1 only", rd_data, 32'h0000_0A63);
    do_write(2'b00, 32'hFFFF_FFFF);
    check("R9 no lane selected", rd_data, 32'h0000_0A63);
    run_rand(30, "R9 outputs after lane writes");

    // R3 R5 R7 sweep: both channels running, different sources
    for (int d = 0; d < 16; d++) begin
      for (int k = 0; k < 4; k++) begin
        int c;
        c = (k == 0) ? ((d + 2) / 2) - 1 : (k == 1) ? 0 : (k == 2) ? d : 15;
        do_write(2'b11, 32'h0);
        do_write(2'b11, {lane(1, 1, 15 - d, (16 - d) / 2), lane(1, 0, d, c)});
        run_rand(40, "R3 R5 R7 sweep");
      end
    end

    // R6 divide zero pass-through
    do_write(2'b11, {lane(1, 0, 0, 9), lane(1, 1, 0, 5)});
    run_rand(40, "R6 pass-through");

    // R7 unselected source ignored: only tick_a pulses, channel 0 on source b
    do_write(2'b11, {lane(0, 0, 0, 0), lane(1, 1, 2, 0)});
    run_fixed(12, 1'b1, 1'b0, "R7 unselected source");
    run_fixed(1, 1'b0, 1'b0, "R7 phase still zero");
    check("R7 output stays low", {31'd0, clk_out[0]}, 32'h0);

    // R8 deferred update: d=3 c=1, advance two ticks, reprogram to d=9 c=4
    do_write(2'b11, 32'h0);
    do_write(2'b01, {16'h0, lane(1, 0, 3, 1)});
    run_fixed(2, 1'b1, 1'b0, "R8 run old");
    do_write(2'b01, {16'h0, lane(1, 0, 9, 4)});
    run_fixed(1, 1'b0, 1'b0, "R8 phase 2 old cmp high");
    check("R8 old compare still active", {31'd0, clk_out[0]}, 32'h1);
    run_fixed(14, 1'b1, 1'b0, "R8 new period");

    // R4 disable mid-period then re-enable
    do_write(2'b01, {16'h0, lane(1, 0, 7, 2)});
    run_fixed(5, 1'b1, 1'b0, "R4 running");
    do_write(2'b01, {16'h0, lane(0, 0, 7, 2)});
    run_fixed(6, 1'b1, 1'b1, "R4 disabled low");
    check("R4 disabled output", {31'd0, clk_out[0]}, 32'h0);
    do_write(2'b01, {16'h0, lane(1, 0, 7, 2)});
    run_fixed(3, 1'b0, 1'b0, "R4 enabled at phase 0");
    check("R4 restart low at phase 0", {31'd0, clk_out[0]}, 32'h0);
    run_rand(40, "R4 restart");

    // R5 half-duty count over one period for divide 9
    do_write(2'b11, 32'h0);
    do_write(2'b01, {16'h0, lane(1, 0, 9, 4)});
    begin
      int highs;
      highs = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk); ref_tick_a = 1'b0; #1;
        check_outs("R5 half duty");
        if (clk_out[0]) highs++;
        @(negedge clk); ref_tick_a = 1'b1; #1;
      end
      check("R5 half duty high count", highs, 5);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule